// File: doc/BRIEF.md
# VLIW Bundle Length and Format Framer

This block sits at the front of an instruction decoder. It takes a little-endian instruction byte stream in 16-byte chunks and cuts it into instructions. For every instruction it emits one record. A record holds the format index, the number of bytes the instruction occupies, the raw bytes and a flag that marks an illegal encoding.

The length of an instruction is read from a 256-entry table. The table is indexed by the low nibble of the first byte (op0) and the low nibble of the fourth byte. A separate ordered mask ladder, applied to the first four bytes, picks one of 14 formats. The two decoders work independently, and they always agree on wide, narrow and illegal. A wide format is 16 bytes and a narrow one is 8. An instruction may start in one chunk and end in the next, so a 32-byte realignment buffer holds bytes until the whole instruction is present. A flush input throws away everything that is buffered. The next chunk accepted after a flush starts framing at its first byte.

Top module: `vliw_framer`

## Requirements
- R1: When op0 is 0 to 7, the record has length 3 and format 0. When op0 is 8 to B, it has length 2 and format 1. When op0 is C or D, it has length 2 and format 2. When op0 is E, it has length 16, and its format is 4 if bit 27 of the word is set and 7 otherwise.
- R2: When op0 is F, the length depends on the low nibble of byte 3. An even nibble gives 8 bytes. The values 1, 3, 5, 9, B and D give 16 bytes. The values 7 and F mark the instruction as illegal.
- R3: The format is the first hit in this ordered list, on the word w built from bytes 0 to 3 (byte 0 in the least significant position):
  - w[3]=0 gives 0.
  - (w&0xC)=0x8 gives 1.
  - (w&0xE)=0xC gives 2.
  - (w&0x0B00000F)=0x0100000F gives 3.
  - (w&0x0800000F)=0x0800000E gives 4.
  - (w&0x3700000F)=0x0300000F gives 5; the same mask compared with 0x3300000F gives 6.
  - (w&0x0800000F)=0x0000000E gives 7.
  - (w&0x0B00000F)=0x0900000F gives 8.
  - (w&0x3700000F)=0x2300000F gives 9; the same mask compared with 0x1300000F gives 10.
  - (w&0x1900000F)=0x0800000F gives 11; the same mask compared with 0x1800000F gives 12.
  - (w&0x0900000F)=0x0000000F gives 13.
  - No hit reports format 15.
- R4: Formats 3 to 10 always come with length 16, and formats 11 to 13 with length 8. The illegal flag is set exactly when the format is 15. Bytes 1 and 2 change neither the length nor the format.
- R5: An illegal encoding produces one record with the illegal flag set, format 15 and length 1. Framing then moves on by one byte.
- R6: Byte i of the instruction appears at out_bytes[8i+7:8i]. Every byte at or beyond the record's length reads as zero.
- R7: Records leave in stream order, at most one per cycle. A record is emitted only once all of its bytes have been received, including when the instruction straddles two chunks. Trailing bytes of an incomplete instruction produce no record.
- R8: in_ready is high exactly when flush is low and the buffer holds at most 16 bytes. It is high after reset.
- R9: Flush discards all buffered bytes and accepts no chunk in its cycle. No record appears in the cycle after a flush. Byte 0 of the next accepted chunk starts an instruction.
- R10: A record becomes valid in the cycle right after the chunk that completes it is accepted, if no earlier record is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard buffered bytes and restart framing |
| in_valid | input | 1 | A chunk is offered |
| in_ready | output | 1 | The block can take a full chunk |
| in_data | input | 128 | Chunk bytes; byte 0 is in bits 7:0 |
| out_valid | output | 1 | A record is present this cycle |
| out_fmt | output | 4 | Format index 0 to 13, or 15 for an illegal encoding |
| out_len | output | 5 | Bytes consumed by this record (1 for an illegal encoding) |
| out_illegal | output | 1 | The encoding is illegal |
| out_bytes | output | 128 | Instruction bytes, zero past the length |

## Verification
The assertions check, on every record, the relations between the decoders:
- the length chosen by op0 and the byte-3 nibble;
- the pairing of wide or narrow formats with lengths 16 or 8;
- agreement on illegal encodings;
- zero bytes past the length;
- the flush and ready rules.

Some behaviour only the bench scenarios can show:
- whether the whole byte-0-nibble by byte-3 space decodes to the exact format index;
- whether a long mixed stream is framed at the right boundaries across chunk edges, with no record lost or repeated;
- whether backpressure releases after the buffer drains below the chunk size.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int INSN_BYTES = 16;
    localparam int LEN_W      = $clog2(INSN_BYTES + 1);
    localparam int FMT_W      = 4;
    localparam logic [FMT_W-1:0] FMT_NONE = 4'hF;

    // Length table cell: idx = {byte3 low nibble, op0}; 0 marks illegal.
    function automatic logic [LEN_W-1:0] lut_len(input logic [7:0] idx);
        logic [3:0] op0;
        logic [3:0] sel;
        op0 = idx[3:0];
        sel = idx[7:4];
        if (op0 < 4'h8)                   return LEN_W'(3);
        else if (op0 < 4'hE)              return LEN_W'(2);
        else if (op0 == 4'hE)             return LEN_W'(16);
        else if (!sel[0])                 return LEN_W'(8);
        else if (sel == 4'h7 || sel == 4'hF) return LEN_W'(0);
        else                              return LEN_W'(16);
    endfunction
endpackage

// File: rtl/framer_len_dec.sv
module framer_len_dec
    import framer_pkg::*;
(
    input  logic [3:0]       op0,
    input  logic [3:0]       sel_nib,
    output logic [LEN_W-1:0] len,
    output logic             bad
);
    localparam int CELLS = 256;

    logic [LEN_W-1:0] table_w [CELLS];

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        assign table_w[i] = lut_len(8'(i));
    end

    assign len = table_w[{sel_nib, op0}];
    assign bad = (len == '0);
endmodule

// File: rtl/framer_fmt_dec.sv
module framer_fmt_dec
    import framer_pkg::*;
(
    input  logic [31:0]      word,
    output logic [FMT_W-1:0] fmt
);
    always_comb begin
        if      ((word & 32'h0000_0008) == 32'h0)          fmt = 4'd0;
        else if ((word & 32'h0000_000C) == 32'h8)          fmt = 4'd1;
        else if ((word & 32'h0000_000E) == 32'hC)          fmt = 4'd2;
        else if ((word & 32'h0B00_000F) == 32'h0100_000F) fmt = 4'd3;
        else if ((word & 32'h0800_000F) == 32'h0800_000E) fmt = 4'd4;
        else if ((word & 32'h3700_000F) == 32'h0300_000F) fmt = 4'd5;
        else if ((word & 32'h3700_000F) == 32'h3300_000F) fmt = 4'd6;
        else if ((word & 32'h0800_000F) == 32'h0000_000E) fmt = 4'd7;
        else if ((word & 32'h0B00_000F) == 32'h0900_000F) fmt = 4'd8;
        else if ((word & 32'h3700_000F) == 32'h2300_000F) fmt = 4'd9;
        else if ((word & 32'h3700_000F) == 32'h1300_000F) fmt = 4'd10;
        else if ((word & 32'h1900_000F) == 32'h0800_000F) fmt = 4'd11;
        else if ((word & 32'h1900_000F) == 32'h1800_000F) fmt = 4'd12;
        else if ((word & 32'h0900_000F) == 32'h0000_000F) fmt = 4'd13;
        else                                               fmt = FMT_NONE;
    end
endmodule

// File: rtl/vliw_framer.sv
module vliw_framer
    import framer_pkg::*;
#(
    parameter int CHUNK_BYTES = 16,
    parameter int BUF_BYTES   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CHUNK_BYTES*8-1:0] in_data,
    output logic                     out_valid,
    output logic [FMT_W-1:0]         out_fmt,
    output logic [LEN_W-1:0]         out_len,
    output logic                     out_illegal,
    output logic [INSN_BYTES*8-1:0]  out_bytes
);
    localparam int CNT_W    = $clog2(BUF_BYTES + 1);
    localparam int BUF_W    = BUF_BYTES * 8;
    localparam int HDR      = 4;
    localparam int ROOM_MAX = BUF_BYTES - CHUNK_BYTES;

    typedef struct packed {
        logic [BUF_W-1:0] bytes;
        logic [CNT_W-1:0] cnt;
    } frame_t;

    frame_t s_d, s_q;

    logic [LEN_W-1:0] tab_len;
    logic             tab_bad;
    logic [FMT_W-1:0] lad_fmt;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] consume;
    logic [CNT_W-1:0] rem;
    logic             fire;
    logic             hdr_ok;
    logic             accept;
    logic [BUF_W-1:0] chunk_ext;
    logic [BUF_W-1:0] shifted;

    framer_len_dec u_len (
        .op0     (s_q.bytes[3:0]),
        .sel_nib (s_q.bytes[27:24]),
        .len     (tab_len),
        .bad     (tab_bad)
    );

    framer_fmt_dec u_fmt (
        .word (s_q.bytes[31:0]),
        .fmt  (lad_fmt)
    );

    assign in_ready = !flush && (s_q.cnt <= CNT_W'(ROOM_MAX));

    always_comb begin
        s_d       = s_q;
        need      = tab_bad ? CNT_W'(1) : CNT_W'(tab_len);
        hdr_ok    = (s_q.bytes[3:0] != 4'hF) || (s_q.cnt >= CNT_W'(HDR));
        fire      = !flush && (s_q.cnt != '0) && hdr_ok && (s_q.cnt >= need);
        consume   = fire ? need : '0;
        rem       = s_q.cnt - consume;
        accept    = in_valid && in_ready;
        chunk_ext = BUF_W'(in_data);
        shifted   = s_q.bytes >> (8 * consume);
        if (flush) begin
            s_d = '0;
        end else begin
            s_d.bytes = shifted | (accept ? (chunk_ext << (8 * rem)) : '0);
            s_d.cnt   = rem + (accept ? CNT_W'(CHUNK_BYTES) : CNT_W'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid   = fire;
    assign out_fmt     = lad_fmt;
    assign out_illegal = tab_bad;
    assign out_len     = tab_bad ? LEN_W'(1) : tab_len;

    for (genvar b = 0; b < INSN_BYTES; b++) begin : g_out_byte
        assign out_bytes[8*b +: 8] = (LEN_W'(b) < out_len) ? s_q.bytes[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/vliw_framer_chk.sv
module vliw_framer_chk
    import framer_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic [FMT_W-1:0]        out_fmt,
    input logic [LEN_W-1:0]        out_len,
    input logic                    out_illegal,
    input logic [INSN_BYTES*8-1:0] out_bytes
);
    logic [3:0] op0;
    assign op0 = out_bytes[3:0];

    AST_CORE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !op0[3] |-> out_len == 5'd3 && out_fmt == 4'd0); // R1
    AST_DENSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && op0 >= 4'h8 && op0 <= 4'hD |-> out_len == 5'd2); // R1
    AST_E_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && op0 == 4'hE |-> out_len == 5'd16); // R1
    AST_F_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && op0 == 4'hF && !out_illegal |-> out_len == (out_bytes[24] ? 5'd16 : 5'd8)); // R2
    AST_WIDE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fmt >= 4'd3 && out_fmt <= 4'd10 |-> out_len == 5'd16); // R4
    AST_NARROW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fmt >= 4'd11 && out_fmt <= 4'd13 |-> out_len == 5'd8); // R4
    AST_ILLEGAL_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_illegal == (out_fmt == FMT_NONE)); // R4
    AST_ILLEGAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_illegal |-> out_len == 5'd1 && op0 == 4'hF); // R5
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bytes >> (8 * out_len)) == '0); // R6
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R9
    AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready); // R8
endmodule

bind vliw_framer vliw_framer_chk u_chk (.*);

// File: tb/vliw_framer_test.sv
module vliw_framer_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic [3:0]   out_fmt;
    logic [4:0]   out_len;
    logic         out_illegal;
    logic [127:0] out_bytes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vliw_framer uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_fmt(out_fmt), .out_len(out_len), .out_illegal(out_illegal),
        .out_bytes(out_bytes)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_bytes(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s bytes: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference length, written from the nibble rules: 0 = illegal.
    function automatic int ref_len(input logic [7:0] b0, input logic [7:0] b3);
        case (b0[3:0])
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: return 3;
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD:             return 2;
            4'hE:                                           return 16;
            default: case (b3[3:0])
                4'h7, 4'hF:                         return 0;
                4'h1, 4'h3, 4'h5, 4'h9, 4'hB, 4'hD: return 16;
                default:                            return 8;
            endcase
        endcase
    endfunction

    function automatic int ref_fmt(input logic [31:0] w);
        if (w[3] == 1'b0)                          return 0;
        if ((w & 32'hC) == 32'h8)                  return 1;
        if ((w & 32'hE) == 32'hC)                  return 2;
        if ((w & 32'h0B00000F) == 32'h0100000F)    return 3;
        if ((w & 32'h0800000F) == 32'h0800000E)    return 4;
        if ((w & 32'h3700000F) == 32'h0300000F)    return 5;
        if ((w & 32'h3700000F) == 32'h3300000F)    return 6;
        if ((w & 32'h0800000F) == 32'h0000000E)    return 7;
        if ((w & 32'h0B00000F) == 32'h0900000F)    return 8;
        if ((w & 32'h3700000F) == 32'h2300000F)    return 9;
        if ((w & 32'h3700000F) == 32'h1300000F)    return 10;
        if ((w & 32'h1900000F) == 32'h0800000F)    return 11;
        if ((w & 32'h1900000F) == 32'h1800000F)    return 12;
        if ((w & 32'h0900000F) == 32'h0000000F)    return 13;
        return 15;
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Stream test storage
    localparam int NCHUNK = 64;
    localparam int NBYTES = NCHUNK * 16;
    logic [7:0] sbytes [NBYTES];
    int exp_pos [NBYTES];
    int exp_len [NBYTES];
    int exp_fmt [NBYTES];
    int exp_n = 0;
    int rec_i = 0;
    bit stream_on = 1'b0;

    function automatic logic [127:0] exp_rec_bytes(input int pos, input int len);
        logic [127:0] r = '0;
        for (int k = 0; k < 16; k++)
            if (k < len) r[8*k +: 8] = sbytes[pos + k];
        return r;
    endfunction

    always @(negedge clk) begin
        if (stream_on && out_valid) begin
            if (rec_i < exp_n) begin
                chk(out_fmt == 4'(exp_fmt[rec_i]), "R7", "stream fmt", out_fmt, exp_fmt[rec_i]);
                chk(out_len == 5'(exp_len[rec_i]), "R7", "stream len", out_len, exp_len[rec_i]);
                chk(out_illegal == (exp_fmt[rec_i] == 15), "R5", "stream illegal",
                    out_illegal, exp_fmt[rec_i] == 15);
                chk_bytes("R6", out_bytes, exp_rec_bytes(exp_pos[rec_i], exp_len[rec_i]));
            end else begin
                chk(1'b0, "R7", "extra record", rec_i, exp_n);
            end
            rec_i++;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] ch;
        // Reset state
        step(); step();
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R8", "reset in_ready", in_ready, 1);

        // Backpressure with illegal bytes (0xFF: op0 F, nibble F)
        step();
        in_valid = 1'b1;
        in_data  = {16{8'hFF}};
        step();                       // first chunk accepted
        step();                       // second chunk accepted, one consumed
        in_valid = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R8", "ready low with 31 bytes", in_ready, 0);
        chk(out_valid && out_illegal, "R5", "illegal record", {out_valid, out_illegal}, 3);
        chk(out_len == 5'd1, "R5", "illegal length", out_len, 1);
        chk(out_fmt == 4'hF, "R5", "illegal fmt", out_fmt, 15);
        chk_bytes("R6", out_bytes, 128'hFF);
        for (int k = 1; k <= 20; k++) begin
            step();
            @(negedge clk);
            chk(in_ready == (31 - k <= 16), "R8", "ready release", in_ready, 31 - k <= 16);
        end
        // Flush clears the leftover bytes
        step();
        flush = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "no record during flush", out_valid, 0);
        chk(in_ready == 1'b0, "R8", "ready low in flush", in_ready, 0);
        step();
        flush = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "empty after flush", out_valid, 0);

        // Straddling stream of random bytes
        for (int i = 0; i < NBYTES; i++) sbytes[i] = 8'($urandom);
        begin
            int p = 0;
            while (p + 1 <= NBYTES) begin
                int l, n;
                logic [31:0] w;
                if (sbytes[p][3:0] == 4'hF && p + 4 > NBYTES) break;
                w = {(p + 3 < NBYTES) ? sbytes[p+3] : 8'h00,
                     (p + 2 < NBYTES) ? sbytes[p+2] : 8'h00,
                     (p + 1 < NBYTES) ? sbytes[p+1] : 8'h00, sbytes[p]};
                l = ref_len(w[7:0], w[31:24]);
                n = (l == 0) ? 1 : l;
                if (p + n > NBYTES) break;
                exp_pos[exp_n] = p;
                exp_len[exp_n] = n;
                exp_fmt[exp_n] = ref_fmt(w);
                exp_n++;
                p += n;
            end
        end
        stream_on = 1'b1;
        step();
        for (int c = 0; c < NCHUNK; c++) begin
            for (int k = 0; k < 16; k++) ch[8*k +: 8] = sbytes[16*c + k];
            in_data  = ch;
            in_valid = 1'b1;
            @(negedge clk);
            while (!in_ready) begin
                @(negedge clk);
            end
            step();
            in_valid = 1'b0;
            if (c % 5 == 4) step();
        end
        repeat (80) step();
        stream_on = 1'b0;
        chk(rec_i == exp_n, "R7", "stream record count", rec_i, exp_n);

        // Exhaustive sweep: byte0 low nibble x byte3
        for (int combo = 0; combo < 4096; combo++) begin
            logic [7:0] b0, b3;
            int el, ef;
            b0 = {4'($urandom), combo[3:0]};
            b3 = combo[11:4];
            ch = {$urandom, $urandom, $urandom, $urandom};
            ch[7:0]   = b0;
            ch[31:24] = b3;
            el = ref_len(b0, b3);
            ef = ref_fmt(ch[31:0]);
            step();
            flush = 1'b1;
            step();
            flush    = 1'b0;
            in_valid = 1'b1;
            in_data  = ch;
            @(negedge clk);
            chk(out_valid == 1'b0, "R9", "sweep empty after flush", out_valid, 0);
            step();
            in_valid = 1'b0;
            @(negedge clk);
            chk(out_valid == 1'b1, "R10", "sweep record valid", out_valid, 1);
            if (el == 0) begin
                chk(out_illegal && out_len == 5'd1 && out_fmt == 4'hF, "R2",
                    "sweep illegal", {out_illegal, out_fmt, out_len}, {1'b1, 4'hF, 5'd1});
            end else begin
                chk(!out_illegal && out_len == 5'(el), "R1",
                    "sweep length", out_len, el);
            end
            chk(out_fmt == 4'(ef), "R3", "sweep format", out_fmt, ef);
            chk((ef >= 3 && ef <= 10) ? el == 16 : (ef >= 11 && ef <= 13) ? el == 8 :
                (ef == 15) ? el == 0 : 1'b1, "R4", "reference pairing", ef, el);
            chk_bytes("R6", out_bytes, ch & ((el == 0) ? 128'hFF :
                      (el == 16) ? {128{1'b1}} : ((128'h1 << (8 * el)) - 1)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule